// File: doc/BRIEF.md
# Write-Back Two-Way Data Cache Controller

This block is a data cache that sits between a processor load/store port and a next-level memory port. Each set holds two lines. A line is chosen by a per-set round-robin pointer. Stores only touch the line. A modified line reaches memory only when it is displaced, and on a store miss the line is allocated first. The processor issues one word access at a time with a request/ready handshake and per-byte write enables. It receives a one-cycle completion pulse, the read word, and a flag that tells whether the first tag lookup hit.

The memory side moves whole lines. Displaced modified lines are parked in a small victim store. That store empties to memory whenever the port is free, so the processor does not wait for the write-back. When a line fill and a parked write compete for the port, the line fill goes first. A miss looks in the victim store before it asks memory. If the line is parked there, the fill is served from the store and the entry is withdrawn, so stale memory data is never returned. The geometry (sets, words per line, word width, store depth) is set by parameters. The defaults are a small simulation size.

Top module: `dcache_wb`

## Requirements
- R1: After reset no line is valid, every round-robin pointer selects way 0, `cpu_ready` is high and `mem_valid` is low. The first access to any line therefore misses.
- R2: An access is accepted on a rising edge where `cpu_req` and `cpu_ready` are both high. `cpu_ready` stays low until the access completes. `cpu_done` is a single-cycle pulse.
- R3: An access to a resident line sets `cpu_done` on the second rising edge after acceptance, with `cpu_hit` high. A read returns the word at word offset `cpu_addr[WSEL_W-1:0]` of the line.
- R4: A read miss issues one line read (`mem_we` low) at line address `cpu_addr[WADDR_W-1:WSEL_W]`, installs the line, and returns the correct word with `cpu_hit` low.
- R5: A store miss fetches the line, merges the store into it and marks it modified. No memory write takes place at that point.
- R6: A store changes only the bytes whose `cpu_be` bit is set. Bit i covers data bits 8i+7..8i.
- R7: The line replaced in a set is the oldest one filled in that set, whatever hits occurred since.
- R8: Displacing a modified line causes exactly one line write of its merged contents to its own line address. Displacing a clean line, or a store hit, causes no memory write.
- R9: A miss on a line held in the victim store is served from the store. It issues no memory read, the line comes back as modified, and that parked entry is never written to memory.
- R10: A line read takes the memory port ahead of pending victim writes. Its address is held stable until `mem_ready`.
- R11: A miss whose victim is modified waits while the victim store is full. It resumes once an entry has drained to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | WADDR_W | Word address |
| cpu_be | input | DATA_W/8 | Store byte enables |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Ready to accept an access |
| cpu_done | output | 1 | Access complete (one cycle) |
| cpu_hit | output | 1 | Completed access hit on first lookup |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_done` |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | WADDR_W-WSEL_W | Line address |
| mem_wdata | output | WORDS*DATA_W | Line write data |
| mem_ready | input | 1 | Memory accepts request |
| mem_rvalid | input | 1 | Line read data valid |
| mem_rdata | input | WORDS*DATA_W | Line read data |

## Verification
The bench tells first-in-first-out replacement apart from least-recently-used. It hits the older line before forcing a third fill. A design that tracked recency would evict the wrong line, and the later hit/miss pattern would show it.

It blocks memory writes while reads proceed. This parks a modified line and then reads it back. A design that skipped the victim-store lookup would return stale memory data or issue an extra read. Under the same blocking it fills the victim store to force a stall. A design with no full check would overwrite a parked line and lose its data, which shows up when the line is read back.

Byte-enable merges on store misses and store hits are compared word by word against an arithmetic shadow memory. Line-write counts expose write-backs of clean lines and missing write-backs of modified lines.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_FREQ  = 2'd2,
    ST_FWAIT = 2'd3
  } dc_state_e;
endpackage

// File: rtl/dc_way.sv
// One way of the cache: tag/data storage without reset (RAM style), valid and dirty bits with reset.
module dc_way #(
  parameter int SETS   = 4,
  parameter int TAG_W  = 6,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [$clog2(SETS)-1:0]       idx,
  output logic                          rd_valid,
  output logic                          rd_dirty,
  output logic [TAG_W-1:0]              rd_tag,
  output logic [WORDS*DATA_W-1:0]       rd_data,
  input  logic                          fill_en,
  input  logic [TAG_W-1:0]              fill_tag,
  input  logic [WORDS*DATA_W-1:0]       fill_data,
  input  logic                          fill_dirty,
  input  logic                          st_en,
  input  logic [$clog2(WORDS)-1:0]      st_word,
  input  logic [DATA_W/8-1:0]           st_be,
  input  logic [DATA_W-1:0]             st_wdata
);
  localparam int BLK_W  = WORDS * DATA_W;
  localparam int BE_W   = DATA_W / 8;
  localparam int WSEL_W = $clog2(WORDS);

  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [BLK_W-1:0]  data_mem [SETS];

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_tag   = tag_mem[idx];
  assign rd_data  = data_mem[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= fill_dirty;
    end else if (st_en) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_mem[idx]  <= fill_tag;
      data_mem[idx] <= fill_data;
    end else if (st_en) begin
      for (int w = 0; w < WORDS; w++) begin
        for (int b = 0; b < BE_W; b++) begin
          if (st_word == WSEL_W'(w) && st_be[b])
            data_mem[idx][w*DATA_W + b*8 +: 8] <= st_wdata[b*8 +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/dc_victim_buf.sv
// Small store of displaced modified lines, searchable by line address, drained lowest slot first.
module dc_victim_buf #(
  parameter int DEPTH   = 2,
  parameter int BADDR_W = 8,
  parameter int BLK_W   = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push_en,
  input  logic [BADDR_W-1:0] push_addr,
  input  logic [BLK_W-1:0]   push_data,
  input  logic [BADDR_W-1:0] look_addr,
  output logic               look_hit,
  output logic [BLK_W-1:0]   look_data,
  input  logic               take_en,
  output logic               drn_valid,
  output logic [BADDR_W-1:0] drn_addr,
  output logic [BLK_W-1:0]   drn_data,
  input  logic               drn_ack,
  output logic               full
);
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]   ent_v;
  logic [BADDR_W-1:0] ent_a [DEPTH];
  logic [BLK_W-1:0]   ent_d [DEPTH];
  logic [SLOT_W-1:0]  look_idx, free_idx, drn_idx;

  always_comb begin
    look_hit = 1'b0;
    look_idx = '0;
    free_idx = '0;
    drn_idx  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (ent_v[i] && ent_a[i] == look_addr) begin
        look_hit = 1'b1;
        look_idx = SLOT_W'(i);
      end
      if (!ent_v[i]) free_idx = SLOT_W'(i);
      if (ent_v[i])  drn_idx  = SLOT_W'(i);
    end
  end

  assign look_data = ent_d[look_idx];
  assign drn_valid = |ent_v;
  assign drn_addr  = ent_a[drn_idx];
  assign drn_data  = ent_d[drn_idx];
  assign full      = &ent_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v <= '0;
    end else begin
      if (drn_ack)             ent_v[drn_idx]  <= 1'b0;
      if (take_en && look_hit) ent_v[look_idx] <= 1'b0;
      if (push_en)             ent_v[free_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_en) begin
      ent_a[free_idx] <= push_addr;
      ent_d[free_idx] <= push_data;
    end
  end
endmodule

// File: rtl/dcache_wb.sv
module dcache_wb
  import dcache_pkg::*;
#(
  parameter int WADDR_W  = 10,
  parameter int DATA_W   = 32,
  parameter int WORDS    = 4,
  parameter int SETS     = 4,
  parameter int VB_DEPTH = 2
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 cpu_req,
  input  logic                                 cpu_we,
  input  logic [WADDR_W-1:0]                   cpu_addr,
  input  logic [DATA_W/8-1:0]                  cpu_be,
  input  logic [DATA_W-1:0]                    cpu_wdata,
  output logic                                 cpu_ready,
  output logic                                 cpu_done,
  output logic                                 cpu_hit,
  output logic [DATA_W-1:0]                    cpu_rdata,
  output logic                                 mem_valid,
  output logic                                 mem_we,
  output logic [WADDR_W-$clog2(WORDS)-1:0]     mem_addr,
  output logic [WORDS*DATA_W-1:0]              mem_wdata,
  input  logic                                 mem_ready,
  input  logic                                 mem_rvalid,
  input  logic [WORDS*DATA_W-1:0]              mem_rdata
);
  localparam int NWAYS   = 2;
  localparam int BE_W    = DATA_W / 8;
  localparam int WSEL_W  = $clog2(WORDS);
  localparam int IDX_W   = $clog2(SETS);
  localparam int TAG_W   = WADDR_W - WSEL_W - IDX_W;
  localparam int BADDR_W = WADDR_W - WSEL_W;
  localparam int BLK_W   = WORDS * DATA_W;

  dc_state_e          state;
  logic               r_we, missed;
  logic [WADDR_W-1:0] r_addr;
  logic [BE_W-1:0]    r_be;
  logic [DATA_W-1:0]  r_wdata;
  logic [SETS-1:0]    rr;

  logic [IDX_W-1:0]   idx;
  logic [TAG_W-1:0]   tag;
  logic [WSEL_W-1:0]  word;
  logic [BADDR_W-1:0] baddr;
  assign idx   = r_addr[WSEL_W +: IDX_W];
  assign tag   = r_addr[WADDR_W-1 -: TAG_W];
  assign word  = r_addr[WSEL_W-1:0];
  assign baddr = r_addr[WADDR_W-1:WSEL_W];

  logic [NWAYS-1:0] w_valid, w_dirty, hit_vec, fill_en, st_en;
  logic [TAG_W-1:0] w_tag  [NWAYS];
  logic [BLK_W-1:0] w_data [NWAYS];

  logic               vic, vic_dirty, can_go, is_miss;
  logic               vb_hit, vb_full, vb_push, vb_take, vb_drn_valid, vb_drn_ack;
  logic [BLK_W-1:0]   vb_data, vb_drn_data, fill_data, sel_blk;
  logic [BADDR_W-1:0] vb_drn_addr, vic_addr;
  logic               fill_any, fill_from_vb;

  assign vic       = rr[idx];
  assign vic_dirty = w_valid[vic] && w_dirty[vic];
  assign vic_addr  = {w_tag[vic], idx};
  assign can_go    = !(vic_dirty && vb_full);
  assign is_miss   = (state == ST_LOOK) && !(|hit_vec);
  assign vb_push   = is_miss && can_go && vic_dirty;
  assign vb_take   = is_miss && can_go && vb_hit;
  assign fill_from_vb = vb_take;
  assign fill_any  = vb_take || (state == ST_FWAIT && mem_rvalid);
  assign fill_data = fill_from_vb ? vb_data : mem_rdata;
  assign sel_blk   = hit_vec[1] ? w_data[1] : w_data[0];

  for (genvar g = 0; g < NWAYS; g++) begin : g_way
    assign hit_vec[g] = w_valid[g] && (w_tag[g] == tag);
    assign fill_en[g] = fill_any && (vic == 1'(g));
    assign st_en[g]   = (state == ST_LOOK) && hit_vec[g] && r_we;
    dc_way #(.SETS(SETS), .TAG_W(TAG_W), .WORDS(WORDS), .DATA_W(DATA_W)) u_way (
      .clk, .rst, .idx,
      .rd_valid(w_valid[g]), .rd_dirty(w_dirty[g]), .rd_tag(w_tag[g]), .rd_data(w_data[g]),
      .fill_en(fill_en[g]), .fill_tag(tag), .fill_data, .fill_dirty(fill_from_vb),
      .st_en(st_en[g]), .st_word(word), .st_be(r_be), .st_wdata(r_wdata)
    );
  end

  dc_victim_buf #(.DEPTH(VB_DEPTH), .BADDR_W(BADDR_W), .BLK_W(BLK_W)) u_vbuf (
    .clk, .rst,
    .push_en(vb_push), .push_addr(vic_addr), .push_data(w_data[vic]),
    .look_addr(baddr), .look_hit(vb_hit), .look_data(vb_data), .take_en(vb_take),
    .drn_valid(vb_drn_valid), .drn_addr(vb_drn_addr), .drn_data(vb_drn_data),
    .drn_ack(vb_drn_ack), .full(vb_full)
  );

  // Line reads win the port; parked writes go whenever no read is pending.
  assign mem_valid  = (state == ST_FREQ) || vb_drn_valid;
  assign mem_we     = (state != ST_FREQ);
  assign mem_addr   = (state == ST_FREQ) ? baddr : vb_drn_addr;
  assign mem_wdata  = vb_drn_data;
  assign vb_drn_ack = vb_drn_valid && mem_ready && (state != ST_FREQ);
  assign cpu_ready  = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      rr       <= '0;
      missed   <= 1'b0;
      cpu_done <= 1'b0;
      cpu_hit  <= 1'b0;
      r_we     <= 1'b0;
      r_addr   <= '0;
      r_be     <= '0;
      r_wdata  <= '0;
      cpu_rdata <= '0;
    end else begin
      cpu_done <= 1'b0;
      cpu_hit  <= 1'b0;
      unique case (state)
        ST_IDLE: if (cpu_req) begin
          r_we    <= cpu_we;
          r_addr  <= cpu_addr;
          r_be    <= cpu_be;
          r_wdata <= cpu_wdata;
          missed  <= 1'b0;
          state   <= ST_LOOK;
        end
        ST_LOOK: begin
          if (|hit_vec) begin
            cpu_done <= 1'b1;
            cpu_hit  <= !missed;
            if (!r_we) cpu_rdata <= sel_blk[int'(word)*DATA_W +: DATA_W];
            state    <= ST_IDLE;
          end else if (can_go) begin
            missed <= 1'b1;
            if (vb_hit) rr[idx] <= ~rr[idx];
            else        state   <= ST_FREQ;
          end
        end
        ST_FREQ: if (mem_ready) state <= ST_FWAIT;
        ST_FWAIT: if (mem_rvalid) begin
          rr[idx] <= ~rr[idx];
          state   <= ST_LOOK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcache_wb_chk.sv
module dcache_wb_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_req,
  input logic          cpu_ready,
  input logic          cpu_done,
  input logic          cpu_hit,
  input logic          mem_valid,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ready
);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_ready) |=> !cpu_ready);

  assert_hit_only_with_done_R3: assert property (@(posedge clk) disable iff (rst)
    cpu_hit |-> cpu_done);

  assert_read_held_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_we && !mem_ready) |=> (mem_valid && !mem_we && $stable(mem_addr)));
endmodule

bind dcache_wb dcache_wb_chk #(.AW(BADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
  .cpu_done(cpu_done), .cpu_hit(cpu_hit), .mem_valid(mem_valid),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_ready(mem_ready)
);

// File: tb/dcache_wb_bench.sv
`timescale 1ns/1ps
module dcache_wb_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_req = 1'b0, cpu_we = 1'b0;
  logic [9:0]   cpu_addr = '0;
  logic [3:0]   cpu_be = '0;
  logic [31:0]  cpu_wdata = '0;
  logic         cpu_ready, cpu_done, cpu_hit;
  logic [31:0]  cpu_rdata;
  logic         mem_valid, mem_we, mem_ready, mem_rvalid;
  logic [7:0]   mem_addr;
  logic [127:0] mem_wdata, mem_rdata;
  logic         wr_block = 1'b0;

  always #2.5 clk = ~clk;

  dcache_wb u_dcache_wb (.*);

  assign mem_ready = wr_block ? !mem_we : 1'b1;

  // Next-level memory model: 256 lines, read latency of a few cycles.
  logic [127:0] mem_model [256];
  logic         pend;
  logic [7:0]   paddr;
  int           pcnt, rd_cnt, wr_cnt;

  function automatic logic [31:0] pat(input int blk, input int w);
    return 32'hC000_0000 | (blk << 8) | w;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst) begin
      pend <= 1'b0; rd_cnt <= 0; wr_cnt <= 0; pcnt <= 0; paddr <= '0; mem_rdata <= '0;
      for (int b = 0; b < 256; b++)
        for (int w = 0; w < 4; w++) mem_model[b][w*32 +: 32] <= pat(b, w);
    end else begin
      if (mem_valid && mem_ready) begin
        if (mem_we) begin
          mem_model[mem_addr] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          pend <= 1'b1; paddr <= mem_addr; pcnt <= 3;
          rd_cnt <= rd_cnt + 1;
        end
      end
      if (pend) begin
        if (pcnt == 0) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem_model[paddr];
          pend       <= 1'b0;
        end else pcnt <= pcnt - 1;
      end
    end
  end

  logic [31:0] ref_mem [256][4];
  int errors = 0, checks = 0;
  logic [31:0] rd;
  logic        hit;
  int          cyc, r0, w0;
  bit          acc_flag;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input int blk, input int w, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rdo, output logic hito,
                        output int cy);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = {8'(blk), 2'(w)}; cpu_be = be; cpu_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    cy = 1;
    check(cpu_ready == 1'b0, "R2 ready low while busy", 32'(cpu_ready), 32'd0);
    while (!cpu_done && cy < 3000) begin
      @(negedge clk);
      cy++;
    end
    check(cpu_done == 1'b1, "R2 access completes", 32'(cpu_done), 32'd1);
    rdo = cpu_rdata; hito = cpu_hit;
    if (we)
      for (int b = 0; b < 4; b++)
        if (be[b]) ref_mem[blk][w][b*8 +: 8] = wd[b*8 +: 8];
    acc_flag = 1'b1;
    @(negedge clk);
    check(cpu_done == 1'b0, "R2 done is one cycle", 32'(cpu_done), 32'd0);
  endtask

  task automatic rd_chk(input int blk, input int w, input string req);
    access(1'b0, blk, w, 4'h0, 32'h0, rd, hit, cyc);
    check(rd == ref_mem[blk][w], req, rd, ref_mem[blk][w]);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int b = 0; b < 256; b++)
      for (int w = 0; w < 4; w++) ref_mem[b][w] = pat(b, w);
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cpu_ready == 1'b1, "R1 ready after reset", 32'(cpu_ready), 32'd1);
    check(mem_valid == 1'b0, "R1 memory idle after reset", 32'(mem_valid), 32'd0);
    // R1/R4 first read misses and fetches one line
    r0 = rd_cnt;
    rd_chk(0, 2, "R4 read miss data");
    check(hit == 1'b0, "R1 first access misses", 32'(hit), 32'd0);
    check(rd_cnt == r0 + 1, "R4 one line read", rd_cnt, r0 + 1);
    // R3 hit latency
    rd_chk(0, 3, "R3 hit data");
    check(hit == 1'b1, "R3 hit flag", 32'(hit), 32'd1);
    check(cyc == 2, "R3 hit latency", cyc, 2);
    // R4/R8 sweep of 64 lines, all clean: no memory writes
    w0 = wr_cnt;
    for (int b = 0; b < 64; b++) rd_chk(b, b % 4, "R4 sweep read");
    check(wr_cnt == w0, "R8 clean victims not written", wr_cnt, w0);
    // R7 oldest-filled replacement in set 2: P,Q fill, P hit, R fill -> P evicted
    rd_chk(66, 0, "R7 fill P");
    rd_chk(70, 0, "R7 fill Q");
    rd_chk(66, 1, "R7 P resident");
    check(hit == 1'b1, "R7 P hit", 32'(hit), 32'd1);
    rd_chk(74, 0, "R7 fill R");
    rd_chk(70, 2, "R7 Q kept");
    check(hit == 1'b1, "R7 Q still resident", 32'(hit), 32'd1);
    rd_chk(66, 2, "R7 P data");
    check(hit == 1'b0, "R7 P was replaced", 32'(hit), 32'd0);
    // R5/R6 store miss with partial enables
    r0 = rd_cnt; w0 = wr_cnt;
    access(1'b1, 83, 1, 4'b0101, 32'h1122_3344, rd, hit, cyc);
    check(hit == 1'b0, "R5 store miss flag", 32'(hit), 32'd0);
    check(rd_cnt == r0 + 1, "R5 store miss fetches line", rd_cnt, r0 + 1);
    rd_chk(83, 1, "R6 merged bytes after store miss");
    rd_chk(83, 0, "R5 rest of line intact");
    // R6/R8 store hit: no memory traffic
    r0 = rd_cnt;
    access(1'b1, 83, 1, 4'b1000, 32'hAB00_0000, rd, hit, cyc);
    check(hit == 1'b1, "R6 store hit flag", 32'(hit), 32'd1);
    rd_chk(83, 1, "R6 store hit merge");
    check(rd_cnt == r0 && wr_cnt == w0, "R8 store hit no traffic", wr_cnt, w0);
    // R8 displacing the modified line writes it back once
    rd_chk(87, 0, "R8 fill");
    rd_chk(91, 0, "R8 fill");
    repeat (20) @(negedge clk);
    check(wr_cnt == w0 + 1, "R8 one write-back", wr_cnt, w0 + 1);
    check(mem_model[83][63:32] == ref_mem[83][1], "R8 written data", mem_model[83][63:32], ref_mem[83][1]);
    // R9/R10 victim store lookup with memory writes blocked
    access(1'b1, 64, 0, 4'hF, 32'hDEAD_BEEF, rd, hit, cyc);
    rd_chk(68, 0, "R9 fill F");
    w0 = wr_cnt;
    wr_block = 1'b1;
    rd_chk(72, 1, "R10 read passes pending write");
    r0 = rd_cnt;
    rd_chk(64, 0, "R9 data from victim store");
    check(hit == 1'b0, "R9 counted as miss", 32'(hit), 32'd0);
    check(rd_cnt == r0, "R9 no memory read", rd_cnt, r0);
    wr_block = 1'b0;
    repeat (20) @(negedge clk);
    check(wr_cnt == w0, "R9 withdrawn entry not written", wr_cnt, w0);
    // R11 full victim store stalls a modified displacement
    wr_block = 1'b1;
    w0 = wr_cnt;
    access(1'b1, 65, 0, 4'hF, 32'h6565_0001, rd, hit, cyc);
    access(1'b1, 69, 0, 4'hF, 32'h6969_0001, rd, hit, cyc);
    access(1'b1, 73, 0, 4'hF, 32'h7373_0001, rd, hit, cyc);
    access(1'b1, 77, 0, 4'hF, 32'h7777_0001, rd, hit, cyc);
    acc_flag = 1'b0;
    fork
      access(1'b1, 81, 0, 4'hF, 32'h8181_0001, rd, hit, cyc);
      begin
        repeat (40) @(negedge clk);
        check(acc_flag == 1'b0, "R11 stall while store full", 32'(acc_flag), 32'd0);
        wr_block = 1'b0;
      end
    join
    check(acc_flag == 1'b1, "R11 resumes after drain", 32'(acc_flag), 32'd1);
    repeat (20) @(negedge clk);
    check(wr_cnt == w0 + 3, "R11 three write-backs", wr_cnt, w0 + 3);
    rd_chk(65, 0, "R8 written-back line reread");
    rd_chk(81, 0, "R11 stalled store landed");
    // final sweep
    for (int b = 0; b < 96; b++) rd_chk(b, b % 4, "R4 final sweep");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule